// File: doc/BRIEF.md
# Two-Field Bitmap Intersection Classifier

The block sorts each packet against a small table of rules, each made of one prefix on a first header field and one prefix on a second header field. For every field on its own it builds a bitmap with one bit per rule, set where that rule's prefix covers the field value. The two bitmaps and the table's per-rule enable bits are ANDed. The lowest-numbered surviving rule is reported, together with a hit flag and the whole surviving bitmap.

Rules are loaded one at a time through a write port that carries a value and a prefix length for each field, plus an enable bit. An enable-only write form switches a rule on or off without touching its stored prefixes. A classification is requested with a one-cycle strobe on the two field values, and the result appears on registered outputs on the following clock edge.

Top module: `bmx_classifier`

## Requirements
- R1: After reset, out_valid, out_hit, out_idx and out_map are all zero, and every rule is disabled, so a classification before any write gives out_hit = 0.
- R2: A field matches a rule prefix of length L when the L most significant bits of the field equal the L most significant bits of the stored value. L = 0 matches every value, and any L at or above the field width compares all bits.
- R3: Bit i of out_map is set exactly when rule i is enabled and both of its field prefixes match; out_map bit 0 belongs to rule 0.
- R4: When several rules survive, out_idx holds the lowest-numbered one.
- R5: When no rule survives, out_hit is 0, out_idx is 0 and out_map is 0.
- R6: out_valid is high in the cycle after a cycle with in_valid high, and out_hit, out_idx and out_map take that classification's result on the same edge.
- R7: In a cycle after in_valid was low, out_valid is low and out_hit, out_idx and out_map keep their previous values.
- R8: A rule write in the same cycle as a classification does not affect that classification; it is used from the next classification onward.
- R9: A full write (wr_flag_only = 0) to rule wr_idx stores both values, both lengths and wr_rule_on as the enable bit; a rule written with wr_rule_on = 0 never appears in out_map.
- R10: An enable-only write (wr_flag_only = 1) changes only the enable bit of rule wr_idx; its stored prefixes are kept, so re-enabling it restores its earlier matches.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Rule write strobe |
| wr_idx | input | IW | Rule number written |
| wr_flag_only | input | 1 | 1: update the enable bit only |
| wr_rule_on | input | 1 | Enable bit written |
| wr_f1_val | input | W1 | First-field prefix value, MSB aligned |
| wr_f1_len | input | LW1 | First-field prefix length |
| wr_f2_val | input | W2 | Second-field prefix value, MSB aligned |
| wr_f2_len | input | LW2 | Second-field prefix length |
| in_valid | input | 1 | Classification request |
| in_f1 | input | W1 | First header field |
| in_f2 | input | W2 | Second header field |
| out_valid | output | 1 | Result valid |
| out_hit | output | 1 | At least one rule survived |
| out_idx | output | IW | Lowest surviving rule |
| out_map | output | NRULES | Surviving rule bitmap |

## Verification
The table is loaded with a six-rule set that mixes short prefixes, wildcards on either field and overlapping rules, then probed with field pairs that hit one rule, several overlapping rules (showing that the lowest number wins over a more specific rule), or none. A full-length rule with an over-range length separates exact matching from prefix clamping by changing only the last bit. Disabling a rule, re-enabling it with the enable-only write, and writing a wildcard rule in the very cycle of a request tell apart stored prefixes, the enable bit and the timing of a write.

// File: rtl/bmx_classifier.sv
module bmx_classifier #(
  parameter int NRULES = 8,
  parameter int W1     = 8,
  parameter int W2     = 8,
  localparam int IW    = $clog2(NRULES),
  localparam int LW1   = $clog2(W1 + 1),
  localparam int LW2   = $clog2(W2 + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IW-1:0]     wr_idx,
  input  logic              wr_flag_only,
  input  logic              wr_rule_on,
  input  logic [W1-1:0]     wr_f1_val,
  input  logic [LW1-1:0]    wr_f1_len,
  input  logic [W2-1:0]     wr_f2_val,
  input  logic [LW2-1:0]    wr_f2_len,
  input  logic              in_valid,
  input  logic [W1-1:0]     in_f1,
  input  logic [W2-1:0]     in_f2,
  output logic              out_valid,
  output logic              out_hit,
  output logic [IW-1:0]     out_idx,
  output logic [NRULES-1:0] out_map
);

  logic [NRULES-1:0][W1-1:0]  f1_val_q;
  logic [NRULES-1:0][LW1-1:0] f1_len_q;
  logic [NRULES-1:0][W2-1:0]  f2_val_q;
  logic [NRULES-1:0][LW2-1:0] f2_len_q;
  logic [NRULES-1:0]          on_q;

  logic [NRULES-1:0] map1, map2, map_all;
  logic [IW-1:0]     first_idx;

  genvar r, b;
  generate
    for (r = 0; r < NRULES; r++) begin : g_rule
      logic [W1-1:0] m1;
      logic [W2-1:0] m2;
      for (b = 0; b < W1; b++) begin : g_m1
        assign m1[b] = LW1'(W1 - 1 - b) < f1_len_q[r];
      end
      for (b = 0; b < W2; b++) begin : g_m2
        assign m2[b] = LW2'(W2 - 1 - b) < f2_len_q[r];
      end
      assign map1[r] = ((in_f1 ^ f1_val_q[r]) & m1) == '0;
      assign map2[r] = ((in_f2 ^ f2_val_q[r]) & m2) == '0;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          f1_val_q[r] <= '0;
          f1_len_q[r] <= '0;
          f2_val_q[r] <= '0;
          f2_len_q[r] <= '0;
          on_q[r]     <= 1'b0;
        end else if (wr_en && wr_idx == IW'(r)) begin
          on_q[r] <= wr_rule_on;
          if (!wr_flag_only) begin
            f1_val_q[r] <= wr_f1_val;
            f1_len_q[r] <= wr_f1_len;
            f2_val_q[r] <= wr_f2_val;
            f2_len_q[r] <= wr_f2_len;
          end
        end
      end
    end
  endgenerate

  assign map_all = map1 & map2 & on_q;

  always_comb begin
    first_idx = '0;
    for (int i = NRULES - 1; i >= 0; i--)
      if (map_all[i]) first_idx = IW'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_hit   <= 1'b0;
      out_idx   <= '0;
      out_map   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_hit <= |map_all;
        out_idx <= first_idx;
        out_map <= map_all;
      end
    end
  end

endmodule

// File: rtl/bmx_classifier_chk.sv
module bmx_classifier_chk #(
  parameter int NRULES = 8,
  localparam int IW    = $clog2(NRULES)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              out_valid,
  input logic              out_hit,
  input logic [IW-1:0]     out_idx,
  input logic [NRULES-1:0] out_map
);

  AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid); // R6
  AST_QUIET_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid); // R7
  AST_HOLD_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> $stable(out_map) && $stable(out_idx) && $stable(out_hit)); // R7
  AST_HIT_MATCHES_MAP: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> out_hit == (out_map != '0)); // R3
  AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_hit |-> out_map[out_idx] && ((out_map & ((NRULES'(1) << out_idx) - NRULES'(1))) == '0)); // R4
  AST_MISS_ZERO_IDX: assert property (@(posedge clk) disable iff (!rst_n) out_valid && !out_hit |-> out_idx == '0 && out_map == '0); // R5

endmodule

bind bmx_classifier bmx_classifier_chk #(.NRULES(NRULES)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
  .out_hit(out_hit), .out_idx(out_idx), .out_map(out_map)
);

// File: tb/bmx_classifier_tb.sv
module bmx_classifier_tb;
  localparam int NR = 8;
  localparam int W  = 8;
  localparam int IW = 3;
  localparam int LW = 4;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, wr_flag_only = 0, wr_rule_on = 0, in_valid = 0;
  logic [IW-1:0] wr_idx = 0;
  logic [W-1:0] wr_f1_val = 0, wr_f2_val = 0, in_f1 = 0, in_f2 = 0;
  logic [LW-1:0] wr_f1_len = 0, wr_f2_len = 0;
  logic out_valid, out_hit;
  logic [IW-1:0] out_idx;
  logic [NR-1:0] out_map;

  int checks = 0, errors = 0;
  logic [W-1:0]  m1v [NR], m2v [NR];
  int            m1l [NR], m2l [NR];
  logic          mon [NR];

  always #5 clk = ~clk;

  bmx_classifier #(.NRULES(NR), .W1(W), .W2(W)) u_dut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit pmatch(logic [W-1:0] v, logic [W-1:0] rv, int len);
    for (int i = 0; i < W && i < len; i++)
      if (v[W-1-i] != rv[W-1-i]) return 0;
    return 1;
  endfunction

  function automatic logic [NR-1:0] model(logic [W-1:0] a, logic [W-1:0] b);
    logic [NR-1:0] m = '0;
    for (int r = 0; r < NR; r++)
      m[r] = mon[r] && pmatch(a, m1v[r], m1l[r]) && pmatch(b, m2v[r], m2l[r]);
    return m;
  endfunction

  function automatic int lowest(logic [NR-1:0] m);
    for (int r = 0; r < NR; r++) if (m[r]) return r;
    return 0;
  endfunction

  task automatic set_wr(int idx, bit only, bit on, logic [W-1:0] v1, int l1, logic [W-1:0] v2, int l2);
    wr_en = 1; wr_idx = IW'(idx); wr_flag_only = only; wr_rule_on = on;
    wr_f1_val = v1; wr_f1_len = LW'(l1); wr_f2_val = v2; wr_f2_len = LW'(l2);
  endtask

  task automatic upd_model(int idx, bit only, bit on, logic [W-1:0] v1, int l1, logic [W-1:0] v2, int l2);
    mon[idx] = on;
    if (!only) begin m1v[idx] = v1; m1l[idx] = l1; m2v[idx] = v2; m2l[idx] = l2; end
  endtask

  task automatic write_rule(int idx, bit only, bit on, logic [W-1:0] v1, int l1, logic [W-1:0] v2, int l2);
    @(negedge clk);
    set_wr(idx, only, on, v1, l1, v2, l2);
    @(posedge clk);
    upd_model(idx, only, on, v1, l1, v2, l2);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic classify(string req, logic [W-1:0] a, logic [W-1:0] b);
    logic [NR-1:0] e;
    @(negedge clk);
    in_valid = 1; in_f1 = a; in_f2 = b;
    e = model(a, b);
    @(posedge clk); #1;
    check({req, " valid"}, 32'(out_valid), 1);
    check({req, " map"}, 32'(out_map), 32'(e));
    check({req, " hit"}, 32'(out_hit), 32'(e != 0));
    check({req, " idx"}, 32'(out_idx), 32'(lowest(e)));
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic t_reset;
    check("R1 valid", 32'(out_valid), 0);
    check("R1 hit", 32'(out_hit), 0);
    check("R1 idx", 32'(out_idx), 0);
    check("R1 map", 32'(out_map), 0);
    classify("R1 empty table", 8'h00, 8'h00);
  endtask

  task automatic t_load;
    write_rule(0, 0, 1, 8'h00, 2, 8'h00, 0);
    write_rule(1, 0, 1, 8'h00, 1, 8'h40, 2);
    write_rule(2, 0, 1, 8'h80, 1, 8'h00, 1);
    write_rule(3, 0, 1, 8'h00, 2, 8'h00, 1);
    write_rule(4, 0, 1, 8'h00, 1, 8'h80, 1);
    write_rule(5, 0, 1, 8'h00, 0, 8'h80, 1);
  endtask

  task automatic t_overlap;
    classify("R3 R4 overlap", 8'h10, 8'h50);
    check("R4 fixed map 0x0B", 32'(out_map), 32'h0B);
    classify("R2 R3 single", 8'hC0, 8'h20);
    check("R3 fixed map 0x04", 32'(out_map), 32'h04);
    classify("R4 lowest of two", 8'h40, 8'hF0);
    check("R4 fixed idx 4", 32'(out_idx), 4);
    classify("R2 wildcard f1", 8'h80, 8'h80);
  endtask

  task automatic t_exact;
    write_rule(6, 0, 1, 8'hA5, 8, 8'h3C, 9);
    classify("R2 exact hit", 8'hA5, 8'h3C);
    check("R2 exact bit6", 32'(out_map[6]), 1);
    classify("R2 exact last bit", 8'hA5, 8'h3D);
    check("R2 exact miss bit6", 32'(out_map[6]), 0);
  endtask

  task automatic t_enable;
    write_rule(5, 0, 0, 8'h00, 0, 8'h80, 1);
    classify("R9 R5 disabled none", 8'h80, 8'h80);
    check("R5 miss hit", 32'(out_hit), 0);
    write_rule(5, 1, 1, 8'hFF, 3, 8'hFF, 3);
    classify("R10 reenable", 8'h80, 8'h80);
    check("R10 rule5 back", 32'(out_idx), 5);
  endtask

  task automatic t_hold;
    logic [NR-1:0] keep;
    keep = out_map;
    @(negedge clk); in_f1 = 8'h00; in_f2 = 8'h00;
    @(posedge clk); #1;
    check("R7 valid low", 32'(out_valid), 0);
    check("R7 map held", 32'(out_map), 32'(keep));
    check("R7 idx held", 32'(out_idx), 5);
  endtask

  task automatic t_same_cycle;
    logic [NR-1:0] e;
    write_rule(5, 1, 0, 8'h00, 0, 8'h00, 0);
    @(negedge clk);
    in_valid = 1; in_f1 = 8'h80; in_f2 = 8'h80;
    e = model(8'h80, 8'h80);
    set_wr(7, 0, 1, 8'h00, 0, 8'h00, 0);
    @(posedge clk);
    upd_model(7, 0, 1, 8'h00, 0, 8'h00, 0);
    #1;
    check("R8 old table map", 32'(out_map), 32'(e));
    check("R8 old table hit", 32'(out_hit), 0);
    @(negedge clk);
    wr_en = 0; in_valid = 0;
    classify("R8 new rule used", 8'h80, 8'h80);
    check("R8 wildcard idx 7", 32'(out_idx), 7);
  endtask

  initial begin
    for (int r = 0; r < NR; r++) begin m1v[r] = 0; m2v[r] = 0; m1l[r] = 0; m2l[r] = 0; mon[r] = 0; end
    repeat (3) @(posedge clk);
    #1;
    t_reset_pre();
  end

  task automatic t_reset_pre;
    check("R1 in reset valid", 32'(out_valid), 0);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;
    t_reset();
    t_load();
    t_overlap();
    t_exact();
    t_enable();
    t_hold();
    t_same_cycle();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #2000000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule